// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Controller

This block is a byte-wide, register-mapped peripheral. It holds two 16-bit down-counters, one flag register that records timer and shift events, and one enable register. A single active-high interrupt line is driven from the flags and the enables. The counters step only on cycles where the `tick_en` strobe is high. The system derives that strobe from a slow reference, about one sixth of 4.7 MHz. The shift datapath is not part of this block: only its event flag is kept, and the `sr_event` pulse sets it.

Timer A is the general-purpose timer. It runs either one-shot or periodic, as the control register selects, and each run is started by a write to its high byte. Timer B always runs one-shot and free-runs after it expires. A write to its low byte only stages the latch. A write to its high byte commits the whole latch into the counter, arms the timer and clears the flag.

The host port has no stall. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is combinational during `bus_rd`, and the side effects of a read (flag clears) land on that same edge. No valid/ready handshake exists, because no data stream crosses the edge: every transfer completes in one cycle and cannot be back-pressured.

Top module: `twin_timer_irq`

## Requirements
- R1: After reset, both latches and both counters hold 0xFFFF and both timers are disarmed. The flags, the enables and the control register read 0, the enable register reads 0x80, and `irq_o` is low.
- R2: `irq_o` is high exactly when some flag is set whose enable is also set. The flag bits are: bit 0 shift, bit 1 timer B, bit 2 timer A. `irq_o` changes on the same edge as the flag or enable that causes the change.
- R3: A write to the enable register (address 6) with bit 7 = 1 sets every enable whose bit in 2..0 is a one. With bit 7 = 0 it clears those enables. Reading the register returns bit 7 as 1 and the enables in bits 2..0.
- R4: A write to the timer B low address (2) changes only the low latch byte. The timer B count and the high latch byte are left unchanged.
- R5: A write to the timer B high address (3) stores the high latch byte, loads the full 16-bit latch into the counter, arms the timer and clears the timer B flag.
- R6: A read of the timer B low address returns the low byte of the count and clears the timer B flag. `irq_o` drops at that edge unless another enabled flag remains set.
- R7: A read of the timer B high address returns the high byte of the count and leaves every flag unchanged.
- R8: When timer B is armed and holds 0 on a tick, it sets its flag, moves to 0xFFFF and disarms. After that it keeps counting down without flagging until it is reloaded through address 3.
- R9: Timer A is reached at address 0 (low) and address 1 (high), with the same load rules as timer B. Reading address 0 clears the timer A flag. With control bit 0 (address 4) = 1, timer A reloads from its latch on every zero tick and flags every time. With bit 0 = 0 it flags once, then wraps to 0xFFFF without further flags.
- R10: A counter changes only on a cycle where `tick_en` is high or its high byte is written.
- R11: A write of ones to the flag register (address 5) clears the matching flags. Bit 7 of that register reads as the OR of all enabled, set flags.
- R12: A one-cycle `sr_event` pulse sets the shift flag (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe; counters step on cycles where it is high |
| sr_event | input | 1 | Pulse from the shift unit that sets the shift flag |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The assertions assume the host never raises `bus_wr` and `bus_rd` in the same cycle, and that every strobe lasts exactly one clock. The stimulus tasks drive one access at a time and release each strobe after a single edge, so both assumptions always hold. The assertions also assume that `tick_en` and `sr_event` are clean single-bit strobes. The bench toggles these only between edges, and runs timer B through a full 65536-tick wrap to show that it does not flag again.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int NFLAG  = 3;
  localparam int FB_SR  = 0;
  localparam int FB_TB  = 1;
  localparam int FB_TA  = 2;
  localparam int NTMR   = 2;

  typedef enum logic [AW-1:0] {
    RA_TA_LO = 4'd0,
    RA_TA_HI = 4'd1,
    RA_TB_LO = 4'd2,
    RA_TB_HI = 4'd3,
    RA_CTRL  = 4'd4,
    RA_FLAG  = 4'd5,
    RA_ENAB  = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/timer_unit.sv
`timescale 1ns/1ps
module timer_unit #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] wdata,
  input  logic          cont,
  output logic [CW-1:0] count,
  output logic          expire
);
  localparam int HW = CW - DW;

  logic [CW-1:0] latch_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign count  = cnt_q;
  assign expire = tick & armed_q & (cnt_q == '0) & ~ld_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
    end else begin
      if (ld_lo) latch_q[DW-1:0] <= wdata;
      if (ld_hi) latch_q[CW-1:DW] <= wdata[HW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      armed_q <= 1'b0;
    end else if (ld_hi) begin
      cnt_q   <= {wdata[HW-1:0], latch_q[DW-1:0]};
      armed_q <= 1'b1;
    end else if (tick) begin
      if (cnt_q == '0) begin
        if (armed_q && cont) begin
          cnt_q <= latch_q;
        end else begin
          cnt_q   <= '1;
          armed_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4: low-byte load never disturbs the high latch byte
  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> latch_q[CW-1:DW] == $past(latch_q[CW-1:DW]));

  // R5: high-byte load commits the staged latch
  a_r5_hi_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> cnt_q == {$past(wdata[HW-1:0]), $past(latch_q[DW-1:0])});

  // R10: counter holds without a tick or a load
  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_hi) |=> cnt_q == $past(cnt_q));

  // R9: periodic mode reloads from the latch
  a_r9_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cont) |=> cnt_q == $past(latch_q));

  // R8: one-shot expiry wraps and disarms
  a_r8_oneshot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cont) |=> (cnt_q == '1) && !armed_q);
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs #(
  parameter int NF = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr_ev,
  input  logic          en_wr,
  input  logic [DW-1:0] en_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] enables,
  output logic          irq
);
  logic [NF-1:0] flag_q;
  logic [NF-1:0] en_q;

  assign flags   = flag_q;
  assign enables = en_q;
  assign irq     = |(flag_q & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_ev) | set_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_wr) begin
      if (en_wdata[DW-1]) en_q <= en_q | en_wdata[NF-1:0];
      else                en_q <= en_q & ~en_wdata[NF-1:0];
    end
  end

  // R2: interrupt only with some enabled, set source
  a_r2_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0) && (flag_q != '0));

  // R2: a new event on an enabled source raises the line on the next edge
  a_r2_irq_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_ev & en_q)) && !en_wr) |=> irq);

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_chk
      // R11: a set event is never lost to a same-cycle clear
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[gi] |=> flag_q[gi]);
      // R6: a clear without a set removes the flag
      a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev[gi] && !set_ev[gi]) |=> !flag_q[gi]);
    end
  endgenerate
endmodule

// File: rtl/twin_timer_irq.sv
`timescale 1ns/1ps
module twin_timer_irq
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          sr_event,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int PADW = DW - 1 - NFLAG;

  logic            mode_q;
  logic [NTMR-1:0] ld_lo, ld_hi, rd_lo, tmr_exp, tmr_cont;
  logic [CW-1:0]   tmr_cnt [NTMR];
  logic [NFLAG-1:0] set_ev, clr_ev, flags, enables;
  logic            irq;

  // timer 0 is timer A (addresses 0/1), timer 1 is timer B (addresses 2/3)
  genvar ti;
  generate
    for (ti = 0; ti < NTMR; ti++) begin : g_tmr
      localparam logic [AW-1:0] LO_A = AW'(2 * ti);
      localparam logic [AW-1:0] HI_A = AW'(2 * ti + 1);
      assign ld_lo[ti] = bus_wr && (bus_addr == LO_A);
      assign ld_hi[ti] = bus_wr && (bus_addr == HI_A);
      assign rd_lo[ti] = bus_rd && (bus_addr == LO_A);
      if (ti == 0) begin : g_sel_a
        assign tmr_cont[ti] = mode_q;
      end else begin : g_sel_b
        assign tmr_cont[ti] = 1'b0;
      end
      timer_unit #(.CW(CW), .DW(DW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .ld_lo  (ld_lo[ti]),
        .ld_hi  (ld_hi[ti]),
        .wdata  (bus_wdata),
        .cont   (tmr_cont[ti]),
        .count  (tmr_cnt[ti]),
        .expire (tmr_exp[ti])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                  mode_q <= 1'b0;
    else if (bus_wr && (bus_addr == RA_CTRL))    mode_q <= bus_wdata[0];
  end

  always_comb begin
    set_ev        = '0;
    set_ev[FB_SR] = sr_event;
    set_ev[FB_TA] = tmr_exp[0];
    set_ev[FB_TB] = tmr_exp[1];
    clr_ev        = (bus_wr && (bus_addr == RA_FLAG)) ? bus_wdata[NFLAG-1:0] : '0;
    clr_ev[FB_TA] = clr_ev[FB_TA] | rd_lo[0] | ld_hi[0];
    clr_ev[FB_TB] = clr_ev[FB_TB] | rd_lo[1] | ld_hi[1];
  end

  irq_regs #(.NF(NFLAG), .DW(DW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   (set_ev),
    .clr_ev   (clr_ev),
    .en_wr    (bus_wr && (bus_addr == RA_ENAB)),
    .en_wdata (bus_wdata),
    .flags    (flags),
    .enables  (enables),
    .irq      (irq)
  );

  assign irq_o = irq;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        RA_TA_LO: bus_rdata = tmr_cnt[0][DW-1:0];
        RA_TA_HI: bus_rdata = tmr_cnt[0][CW-1:DW];
        RA_TB_LO: bus_rdata = tmr_cnt[1][DW-1:0];
        RA_TB_HI: bus_rdata = tmr_cnt[1][CW-1:DW];
        RA_CTRL:  bus_rdata = {{(DW-1){1'b0}}, mode_q};
        RA_FLAG:  bus_rdata = {irq, {PADW{1'b0}}, flags};
        RA_ENAB:  bus_rdata = {1'b1, {PADW{1'b0}}, enables};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R7: high-byte read of timer B leaves its flag alone
  a_r7_hi_read_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (bus_addr == RA_TB_HI) && !tmr_exp[1])
      |=> flags[FB_TB] == $past(flags[FB_TB]));

  // R12: shift event pulse sets the shift flag
  a_r12_sr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sr_event |=> flags[FB_SR]);
endmodule

// File: tb/tb_twin_timer_irq.sv
`timescale 1ns/1ps
module tb_twin_timer_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       sr_event = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  twin_timer_irq dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sr_event(sr_event),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [3:0] A_TAL = 4'd0, A_TAH = 4'd1, A_TBL = 4'd2, A_TBH = 4'd3;
  localparam logic [3:0] A_CTL = 4'd4, A_FLG = 4'd5, A_ENA = 4'd6;

  // vector: {op, addr, data, expected, requirement}
  // op 0 = write, 1 = read and compare, 2 = data ticks, 3 = compare irq_o
  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    32'h0_6_86_00_03,  // R3 enable timer A and B
    32'h1_6_00_86_03,  // R3 readback
    32'h0_2_03_00_04,  // R4 stage low byte
    32'h1_2_00_FF_04,  // R4 count low unchanged
    32'h1_3_00_FF_04,  // R4 count high unchanged
    32'h0_3_00_00_05,  // R5 commit 0x0003
    32'h1_2_00_03_05,  // R5
    32'h1_3_00_00_05,  // R5
    32'h2_0_03_00_0A,  // R10 three ticks
    32'h1_2_00_00_08,  // R8 at zero
    32'h1_5_00_00_08,  // R8 no flag yet
    32'h3_0_00_00_02,  // R2 irq low
    32'h2_0_01_00_08,  // R8 expiry tick
    32'h1_5_00_82_08,  // R8 flag B + summary bit
    32'h3_0_00_01_02,  // R2 irq high
    32'h1_3_00_FF_07,  // R7 high read
    32'h1_5_00_82_07,  // R7 flag kept
    32'h2_0_05_00_0A,  // R10 five ticks
    32'h1_2_00_FA_06,  // R6 low read clears
    32'h3_0_00_00_06,  // R6 irq dropped
    32'h1_5_00_00_06,  // R6 flag gone
    32'h1_3_00_FF_08   // R8 still counting from 0xFFFF
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(bus_rdata, exp, req);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(posedge clk);
      #1;
      tick_en = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    #1;
    chk({7'b0, irq_o}, {7'b0, exp}, req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_TAL, 8'hFF, "R1");
    rd(A_TAH, 8'hFF, "R1");
    rd(A_TBL, 8'hFF, "R1");
    rd(A_TBH, 8'hFF, "R1");
    rd(A_FLG, 8'h00, "R1");
    rd(A_ENA, 8'h80, "R1");
    rd(A_CTL, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, a;
      logic [7:0] d, e;
      string tag;
      {op, a, d, e} = VEC[i][31:8];
      tag = $sformatf("R%0d vec%0d", VEC[i][7:0], i);
      case (op)
        4'd0: wr(a, d);
        4'd1: rd(a, e, tag);
        4'd2: ticks(int'(d));
        default: chk_irq(e[0], tag);
      endcase
    end

    // R8 full wrap without a second flag: 0xFFFA down to 0, then one more
    ticks(65531);
    rd(A_TBH, 8'hFF, "R8");
    rd(A_FLG, 8'h00, "R8");
    // R8 reload re-arms
    wr(A_TBL, 8'h01);
    wr(A_TBH, 8'h00);
    ticks(2);
    rd(A_FLG, 8'h82, "R8");
    // R5 high write clears flag B
    wr(A_TBH, 8'h00);
    rd(A_FLG, 8'h00, "R5");
    ticks(2);
    // R12 shift event, R6 another enabled flag keeps irq up
    wr(A_ENA, 8'h81);
    sr_event = 1'b1; @(posedge clk); #1 sr_event = 1'b0;
    rd(A_FLG, 8'h83, "R12");
    rd(A_TBL, 8'hFF, "R6");
    chk_irq(1'b1, "R6");
    rd(A_FLG, 8'h81, "R6");
    // R11 write one clears
    wr(A_FLG, 8'h01);
    rd(A_FLG, 8'h00, "R11");
    chk_irq(1'b0, "R11");
    // R3 clear selected enables
    wr(A_ENA, 8'h06);
    rd(A_ENA, 8'h81, "R3");
    wr(A_ENA, 8'h01);
    rd(A_ENA, 8'h80, "R3");
    // R2 set flag with no enable: no irq, summary bit 0
    sr_event = 1'b1; @(posedge clk); #1 sr_event = 1'b0;
    chk_irq(1'b0, "R2");
    rd(A_FLG, 8'h01, "R2");
    wr(A_FLG, 8'h07);

    // R9 one-shot timer A
    wr(A_ENA, 8'h84);
    wr(A_CTL, 8'h00);
    wr(A_TAL, 8'h01);
    wr(A_TAH, 8'h00);
    ticks(2);
    rd(A_FLG, 8'h84, "R9");
    chk_irq(1'b1, "R9");
    wr(A_FLG, 8'h04);
    ticks(2);
    rd(A_FLG, 8'h00, "R9");
    rd(A_TAH, 8'hFF, "R9");
    rd(A_TAL, 8'hFD, "R9");

    // R9 periodic timer A
    wr(A_CTL, 8'h01);
    rd(A_CTL, 8'h01, "R9");
    wr(A_TAL, 8'h02);
    wr(A_TAH, 8'h00);
    ticks(3);
    rd(A_TAH, 8'h00, "R9");
    rd(A_FLG, 8'h84, "R9");
    wr(A_FLG, 8'h04);
    ticks(3);
    rd(A_FLG, 8'h84, "R9");
    rd(A_TAL, 8'h02, "R9");
    rd(A_FLG, 8'h00, "R9");

    // R10 idle cycles without tick
    repeat (5) @(posedge clk);
    #1;
    rd(A_TAL, 8'h02, "R10");

    finish_run();
  end
endmodule